// File: doc/BRIEF.md
# Block-Write Configuration Slave for a Clock Generator

This block is a receive-only two-wire serial slave that loads the configuration bytes of a clock generator. It watches the SCL and SDA lines (synchronised to a faster system clock), drives SDA low only to acknowledge, and keeps a small bank of 8-bit control registers. Their bits enable or disable individual clock outputs and turn spread-spectrum modulation on or off.

The only transaction it accepts is a block write. A host issues a start condition, then the write address 0xD2, then two bytes that are acknowledged and discarded (a command code and a byte count). After that come data bytes, which land in register 0, register 1 and so on. The host may end with a stop after any whole byte. There is no register addressing and no read path. A start condition seen at any point restarts reception at the address byte.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, register 0 holds 0x16, register 1 holds 0xFF, and SDA is not pulled low.
- R2: An address byte of 0xD2 (7-bit address 0x69, R/W bit 0) is acknowledged by pulling SDA low during the ninth clock of that byte.
- R3: Any other address byte, including 0xD3 with R/W set to 1, gets no acknowledge. Every following byte up to the next start is then ignored: it gets no acknowledge and causes no register change.
- R4: The two bytes after an accepted address are acknowledged, and their values are never stored.
- R5: Data bytes are stored in ascending order starting at register 0 in every transfer, and each whole data byte is acknowledged.
- R6: A stop after any whole byte keeps the registers already written and leaves later registers unchanged. A byte cut short by a stop is not stored.
- R7: Data bytes beyond the last register are acknowledged and discarded.
- R8: A repeated start in the middle of a transfer restarts reception at the address byte, and the next data byte goes to register 0 again.
- R9: The spread-spectrum enable output is register 0 bit 3. The two 48 MHz enable outputs are register 0 bits 2:1. The eight memory-clock enable outputs are register 1 bits 7:0. A bit value of 1 means enabled.
- R10: SDA is pulled low only in the acknowledge slot. The pull starts after the SCL falling edge that ends the eighth bit and is released after the SCL falling edge that ends the ninth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired-AND bus level) |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain acknowledge) |
| cfg_o | output | NUM_REGS*8 | All configuration bytes, register 0 in bits 7:0 |
| spread_en_o | output | 1 | Spread-spectrum enable |
| fixed48_en_o | output | 2 | Enables of the two 48 MHz outputs |
| mem_clk_en_o | output | 8 | Enables of the eight memory-clock outputs |

## Verification
The checker monitors several properties on every cycle:
- a register write happens only for a data byte and only to an implemented register index;
- the configuration stays stable in any cycle without a write;
- the acknowledge pull starts and ends only just after an SCL falling edge or a bus condition;
- SDA stays released while an unmatched transfer is being ignored;
- the power-on values are present after reset.

Other behaviour can only be shown by the bench's bus scenarios. These include which byte lands in which register, that the command and count values are thrown away, partial transfers ending on a stop, repeated starts that send the pointer back to register 0, and the fact that a wrong address or R/W value gets no acknowledge on any byte.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    localparam int          BYTE_W   = 8;
    localparam logic [6:0]  DEV_ADDR = 7'h69;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_RECV,
        ENG_ACK,
        ENG_IGNORE
    } eng_state_e;

    typedef enum logic [1:0] {
        STG_ADDR,
        STG_CMD,
        STG_COUNT,
        STG_DATA
    } stage_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic              en;
        logic [7:0]        idx;
        logic [BYTE_W-1:0] data;
    } reg_wr_t;

    function automatic logic [BYTE_W-1:0] reg_default(int unsigned i);
        case (i)
            0:       return 8'h16;
            1:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic stage_e stage_advance(stage_e s);
        case (s)
            STG_ADDR:  return STG_CMD;
            STG_CMD:   return STG_COUNT;
            default:   return STG_DATA;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import cfg_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [SYNC_STAGES:0] scl_p;
    logic [SYNC_STAGES:0] sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[SYNC_STAGES-1:0], scl_i};
            sda_p <= {sda_p[SYNC_STAGES-1:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_p[SYNC_STAGES-1];
    assign scl_old = scl_p[SYNC_STAGES];
    assign sda_now = sda_p[SYNC_STAGES-1];
    assign sda_old = sda_p[SYNC_STAGES];

    always_comb begin
        ev.sda      = sda_now;
        ev.scl_rise = scl_now & ~scl_old;
        ev.scl_fall = ~scl_now & scl_old;
        ev.start    = scl_now & scl_old & sda_old & ~sda_now;
        ev.stop     = scl_now & scl_old & ~sda_old & sda_now;
    end

endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
    import cfg_i2c_pkg::*;
#(
    parameter int NUM_REGS = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    output reg_wr_t wr,
    output logic    sda_pull,
    output logic    ignoring,
    output logic    data_stage
);
    localparam int PTR_W = $clog2(NUM_REGS + 1);

    eng_state_e        state;
    stage_e            stage;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [PTR_W-1:0]  ptr;

    assign ignoring   = (state == ENG_IGNORE);
    assign data_stage = (stage == STG_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENG_IDLE;
            stage    <= STG_ADDR;
            bit_cnt  <= '0;
            shreg    <= '0;
            ptr      <= '0;
            sda_pull <= 1'b0;
            wr       <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.start) begin
                state    <= ENG_RECV;
                stage    <= STG_ADDR;
                bit_cnt  <= '0;
                ptr      <= '0;
                sda_pull <= 1'b0;
            end else if (ev.stop) begin
                state    <= ENG_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    ENG_RECV: begin
                        if (ev.scl_rise && bit_cnt < 4'd8) begin
                            shreg   <= {shreg[BYTE_W-2:0], ev.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (ev.scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (stage == STG_ADDR && shreg != {DEV_ADDR, 1'b0}) begin
                                state <= ENG_IGNORE;
                            end else begin
                                state    <= ENG_ACK;
                                sda_pull <= 1'b1;
                                if (stage == STG_DATA && ptr < PTR_W'(NUM_REGS)) begin
                                    wr.en   <= 1'b1;
                                    wr.idx  <= 8'(ptr);
                                    wr.data <= shreg;
                                    ptr     <= ptr + 1'b1;
                                end
                            end
                        end
                    end
                    ENG_ACK: begin
                        if (ev.scl_fall) begin
                            sda_pull <= 1'b0;
                            state    <= ENG_RECV;
                            stage    <= stage_advance(stage);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_i2c_pkg::*;
#(
    parameter int NUM_REGS = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  reg_wr_t                    wr,
    output logic [NUM_REGS*BYTE_W-1:0] cfg
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                cfg[g*BYTE_W +: BYTE_W] <= reg_default(g);
            else if (wr.en && wr.idx == 8'(g))
                cfg[g*BYTE_W +: BYTE_W] <= wr.data;
        end
    end

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
    import cfg_i2c_pkg::*;
#(
    parameter int NUM_REGS    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_pull_o,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_o,
    output logic                       spread_en_o,
    output logic [1:0]                 fixed48_en_o,
    output logic [7:0]                 mem_clk_en_o
);
    bus_ev_t bus_ev;
    reg_wr_t reg_wr;
    logic    eng_ignoring;
    logic    eng_data_stage;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (bus_ev)
    );

    i2c_wr_engine #(.NUM_REGS(NUM_REGS)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .ev         (bus_ev),
        .wr         (reg_wr),
        .sda_pull   (sda_pull_o),
        .ignoring   (eng_ignoring),
        .data_stage (eng_data_stage)
    );

    cfg_reg_bank #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk (clk),
        .rst (rst),
        .wr  (reg_wr),
        .cfg (cfg_o)
    );

    assign spread_en_o  = cfg_o[3];
    assign fixed48_en_o = cfg_o[2:1];
    assign mem_clk_en_o = cfg_o[15:8];

endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk
    import cfg_i2c_pkg::*;
#(
    parameter int NUM_REGS = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       sda_pull,
    input logic [NUM_REGS*BYTE_W-1:0] cfg,
    input logic                       scl_fall,
    input logic                       start,
    input logic                       stop,
    input logic                       wr_en,
    input logic [7:0]                 wr_idx,
    input logic                       ignoring,
    input logic                       data_stage
);
    function automatic logic [NUM_REGS*BYTE_W-1:0] all_defaults();
        logic [NUM_REGS*BYTE_W-1:0] v;
        for (int i = 0; i < NUM_REGS; i++) v[i*BYTE_W +: BYTE_W] = reg_default(i);
        return v;
    endfunction

    a_r1_reset_defaults: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg == all_defaults() && !sda_pull));

    a_r4_write_only_data: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> data_stage);

    a_r7_idx_in_range: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx < 8'(NUM_REGS)));

    a_r6_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg));

    a_r3_ignore_silent: assert property (@(posedge clk) disable iff (rst)
        ignoring |-> !sda_pull);

    a_r10_pull_after_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> $past(scl_fall));

    a_r10_release_on_event: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_pull) |-> $past(scl_fall || start || stop));

endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sda_pull   (sda_pull_o),
    .cfg        (cfg_o),
    .scl_fall   (bus_ev.scl_fall),
    .start      (bus_ev.start),
    .stop       (bus_ev.stop),
    .wr_en      (reg_wr.en),
    .wr_idx     (reg_wr.idx),
    .ignoring   (eng_ignoring),
    .data_stage (eng_data_stage)
);

// File: tb/cfg_i2c_slave_test.sv
module cfg_i2c_slave_test;
    localparam int NREG = 2;
    localparam int Q    = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic [NREG*8-1:0] cfg;
    logic spread_en;
    logic [1:0] f48_en;
    logic [7:0] mem_en;
    wire  sda_line = sda_m & ~sda_pull;

    cfg_i2c_slave #(.NUM_REGS(NREG)) uut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .cfg_o(cfg), .spread_en_o(spread_en),
        .fixed48_en_o(f48_en), .mem_clk_en_o(mem_en)
    );

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] exp_reg [NREG];
    logic [7:0] dbuf [8];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_q(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        sda_m = 1'b1; wait_q(Q);
    endtask

    task automatic send_bit(bit b);
        sda_m = b;    wait_q(Q);
        scl_m = 1'b1; wait_q(2*Q);
        scl_m = 1'b0; wait_q(Q);
    endtask

    task automatic send_byte(logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wait_q(Q);
        scl_m = 1'b1; wait_q(Q);
        acked = !sda_line;
        wait_q(Q);
        scl_m = 1'b0; wait_q(Q);
        chk("R10 SDA released after ack slot", sda_pull, 0);
    endtask

    task automatic check_regs(string ctx);
        for (int i = 0; i < NREG; i++)
            chk($sformatf("R5/R6 %s reg%0d", ctx, i), cfg[i*8 +: 8], exp_reg[i]);
        chk($sformatf("R9 %s spread", ctx), spread_en, exp_reg[0][3]);
        chk($sformatf("R9 %s 48MHz", ctx), f48_en, exp_reg[0][2:1]);
        chk($sformatf("R9 %s memclk", ctx), mem_en, exp_reg[1]);
    endtask

    task automatic run_xfer(logic [7:0] addr, int n, bit with_stop, string ctx);
        bit a;
        bit ok;
        ok = (addr == 8'hD2);
        bus_start();
        send_byte(addr, a);
        chk($sformatf("R2/R3 %s addr ack", ctx), a, ok);
        send_byte(8'($urandom), a);
        chk($sformatf("R4/R3 %s command ack", ctx), a, ok);
        send_byte(8'($urandom), a);
        chk($sformatf("R4/R3 %s count ack", ctx), a, ok);
        for (int j = 0; j < n; j++) begin
            send_byte(dbuf[j], a);
            chk($sformatf("%s %s data%0d ack", (j >= NREG) ? "R7" : "R5", ctx, j), a, ok);
            if (ok && j < NREG) exp_reg[j] = dbuf[j];
        end
        if (with_stop) bus_stop();
        check_regs(ctx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        exp_reg[0] = 8'h16;
        exp_reg[1] = 8'hFF;
        wait_q(5);
        rst = 1'b0;
        wait_q(3);
        chk("R1 reset reg0", cfg[7:0], 8'h16);
        chk("R1 reset reg1", cfg[15:8], 8'hFF);
        chk("R1 reset sda released", sda_pull, 0);
        check_regs("reset");

        dbuf[0] = 8'h0A; dbuf[1] = 8'h55;
        run_xfer(8'hD2, 2, 1'b1, "full write");

        dbuf[0] = 8'h08; dbuf[1] = 8'hA5; dbuf[2] = 8'hFF; dbuf[3] = 8'h00;
        run_xfer(8'hD2, 4, 1'b1, "R7 extra bytes");

        dbuf[0] = 8'h77; dbuf[1] = 8'h11;
        run_xfer(8'hD3, 2, 1'b1, "R3 read bit");
        run_xfer(8'hA4, 2, 1'b1, "R3 other addr");

        run_xfer(8'hD2, 0, 1'b1, "R6 stop after count");

        dbuf[0] = 8'h14;
        run_xfer(8'hD2, 1, 1'b0, "R6 one byte");
        for (int k = 0; k < 5; k++) send_bit(k[0]);
        bus_stop();
        check_regs("R6 partial byte dropped");

        dbuf[0] = 8'h02;
        run_xfer(8'hD2, 1, 1'b0, "R8 before restart");
        dbuf[0] = 8'h1C;
        run_xfer(8'hD2, 1, 1'b1, "R8 after restart");

        dbuf[0] = 8'h99; dbuf[1] = 8'h98;
        run_xfer(8'h52, 2, 1'b0, "R3 ignored then restart");
        dbuf[0] = 8'h06; dbuf[1] = 8'h3C;
        run_xfer(8'hD2, 2, 1'b1, "R8 restart from ignore");

        for (int t = 0; t < 24; t++) begin
            logic [7:0] addr;
            int n;
            addr = 8'hD2;
            if ($urandom_range(0, 3) == 0) begin
                addr = 8'($urandom);
                if (addr == 8'hD2) addr = 8'hD3;
            end
            n = $urandom_range(0, 4);
            for (int j = 0; j < n; j++) dbuf[j] = 8'($urandom);
            run_xfer(addr, n, ($urandom_range(0, 4) != 0), $sformatf("rand%0d", t));
        end
        bus_stop();
        check_regs("final");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule